// File: doc/BRIEF.md
# Xon/Xoff Software Flow Controller

This block carries out in-band software flow control for a single serial channel. On the receive side it inspects every character delivered by the deserializer and compares it against four programmed flow characters (two "resume" codes and two "stop" codes). It can match a single code, or a pair of codes that must arrive one after the other. A matching stop code halts the local transmitter once the character currently on the wire has finished. A matching resume code lets the transmitter continue. For every received character the block returns a keep/drop verdict, so that flow characters stay out of the receive FIFO.

On the transmit side the block watches the receive FIFO fill level. When the level reaches the halt threshold it asks the serializer to insert the stop code or codes. When the level falls back to the resume threshold it asks for the resume code or codes. Inserted characters are cut to the active word length, like ordinary data.

Two further options are supported. With resume-on-any, any received character restarts a halted transmitter. With special-character mode, the second stop code raises the interrupt flag without halting anything; that flag clears when the interrupt identification register is read.

Top module: `xflow_ctrl`

## Requirements
- R1: After reset tx_halt_o, ins_req_o, xoff_irq_o, rx_out_valid_o and flush_o are 0. A verdict strobe rx_out_valid_o appears exactly one cycle after each rx_valid_i cycle, and at no other time.
- R2: With rx_mode_i = 2'b00 and special mode off, every received character is kept (rx_keep_o = 1) and the halt state never changes.
- R3: With rx_mode_i = 2'b10 the codes on xon_a_i and xoff_a_i are matched; with rx_mode_i = 2'b01 the codes on xon_b_i and xoff_b_i are matched. A matched code is dropped (rx_keep_o = 0). A stop match halts the transmitter and a resume match releases it.
- R4: With rx_mode_i = 2'b11 a stop needs xoff_a_i followed directly by xoff_b_i, and a resume needs xon_a_i followed directly by xon_b_i. The first character of a pair is held, with a verdict of rx_keep_o = 0.
- R5: In mode 2'b11, if a held first character is not followed by its partner, the held character is released as data on flush_o / flush_char_o. This happens together with the verdict for the new character, and the new character is then judged afresh (it may itself start a pair).
- R6: tx_halt_o follows the internal halt decision with one cycle of delay, and only on edges where tx_busy_i is 0. While tx_busy_i is 1, tx_halt_o holds its value.
- R7: A stop match sets xoff_irq_o when xoff_irq_en_i is 1, and a resume match clears it. With xoff_irq_en_i at 0 a stop match still halts but leaves xoff_irq_o at 0.
- R8: With any_resume_i = 1, any received character releases a halted transmitter. This does not clear xoff_irq_o.
- R9: With special_en_i = 1, a character equal to xoff_b_i is kept, does not halt (in any receive mode), and sets xoff_irq_o. A pulse on iir_read_i clears that flag.
- R10: With insertion enabled, the block raises ins_req_o one cycle after fifo_level_i >= halt_thr_i, carrying the stop code. After that stop has been sent, it raises ins_req_o one cycle after fifo_level_i <= resume_thr_i, carrying the resume code. Each is requested once per crossing.
- R11: tx_mode_i selects the inserted codes: 2'b10 uses the A codes, 2'b01 uses the B codes, 2'b11 sends the A code and then the B code back to back, and 2'b00 never raises ins_req_o.
- R12: ins_char_o carries only the low 5, 6, 7 or 8 bits of the code, for word_len_i = 0, 1, 2 or 3; the upper bits are 0.
- R13: ins_req_o stays high with the same character until a cycle with ins_ack_i = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_valid_i | input | 1 | Received character strobe |
| rx_char_i | input | 8 | Received character |
| xon_a_i | input | 8 | Resume code A |
| xon_b_i | input | 8 | Resume code B |
| xoff_a_i | input | 8 | Stop code A |
| xoff_b_i | input | 8 | Stop code B |
| rx_mode_i | input | 2 | Receive match mode |
| tx_mode_i | input | 2 | Insertion mode |
| any_resume_i | input | 1 | Any character resumes |
| special_en_i | input | 1 | Special-character mode |
| xoff_irq_en_i | input | 1 | Stop interrupt enable |
| iir_read_i | input | 1 | Interrupt identification read pulse |
| word_len_i | input | 2 | Word length: 0=5 bits to 3=8 bits |
| fifo_level_i | input | LVL_W | Receive FIFO fill level |
| halt_thr_i | input | LVL_W | Level that triggers a stop insertion |
| resume_thr_i | input | LVL_W | Level that triggers a resume insertion |
| tx_busy_i | input | 1 | Serializer is sending a character |
| ins_ack_i | input | 1 | Serializer took the inserted character |
| tx_halt_o | output | 1 | Hold the transmitter at the next character boundary |
| ins_req_o | output | 1 | Insert request |
| ins_char_o | output | 8 | Character to insert |
| rx_out_valid_o | output | 1 | Verdict strobe |
| rx_keep_o | output | 1 | Write the character to the FIFO |
| flush_o | output | 1 | Release a held first character as data |
| flush_char_o | output | 8 | Released character |
| xoff_irq_o | output | 1 | Stop interrupt flag |

## Verification
The assertions take for granted that the programmed codes are distinct and stay stable while characters are in flight. They also assume that the mode inputs change only between characters, and that ins_ack_i is given only while ins_req_o is high. The stimulus keeps to this: mode and code values are set only when no character or insertion is pending, and each acknowledge is a single-cycle pulse given after the request has been observed. Thresholds are moved only while no insertion is outstanding, so that each crossing gives exactly one request.

// File: rtl/xflow_pkg.sv
package xflow_pkg;
  typedef enum logic [1:0] {PEND_NONE, PEND_XON, PEND_XOFF} pend_e;
  typedef enum logic [1:0] {INS_IDLE, INS_FIRST, INS_SECOND} ins_e;
  localparam logic [1:0] MODE_OFF  = 2'b00;
  localparam logic [1:0] MODE_A    = 2'b10;
  localparam logic [1:0] MODE_B    = 2'b01;
  localparam logic [1:0] MODE_BOTH = 2'b11;
endpackage

// File: rtl/xflow_rx_match.sv
module xflow_rx_match
  import xflow_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rx_valid_i,
  input  logic [CW-1:0] rx_char_i,
  input  logic [CW-1:0] xon_a_i,
  input  logic [CW-1:0] xon_b_i,
  input  logic [CW-1:0] xoff_a_i,
  input  logic [CW-1:0] xoff_b_i,
  input  logic [1:0]    rx_mode_i,
  input  logic          special_en_i,
  output logic          xon_hit_o,
  output logic          xoff_hit_o,
  output logic          spec_hit_o,
  output logic          out_valid_o,
  output logic          keep_o,
  output logic          flush_o,
  output logic [CW-1:0] flush_char_o
);
  pend_e         pend_q, pend_d;
  logic [CW-1:0] pend_char_q;
  logic          keep_d, flush_d;

  always_comb begin
    pend_d     = pend_q;
    keep_d     = 1'b1;
    flush_d    = 1'b0;
    xon_hit_o  = 1'b0;
    xoff_hit_o = 1'b0;
    spec_hit_o = 1'b0;
    if (rx_valid_i) begin
      pend_d  = PEND_NONE;
      flush_d = (pend_q != PEND_NONE);
      if (special_en_i && rx_char_i == xoff_b_i) begin
        spec_hit_o = 1'b1;
      end else begin
        unique case (rx_mode_i)
          MODE_A: begin
            if (rx_char_i == xon_a_i) begin
              xon_hit_o = 1'b1; keep_d = 1'b0;
            end else if (rx_char_i == xoff_a_i) begin
              xoff_hit_o = 1'b1; keep_d = 1'b0;
            end
          end
          MODE_B: begin
            if (rx_char_i == xon_b_i) begin
              xon_hit_o = 1'b1; keep_d = 1'b0;
            end else if (rx_char_i == xoff_b_i) begin
              xoff_hit_o = 1'b1; keep_d = 1'b0;
            end
          end
          MODE_BOTH: begin
            if (pend_q == PEND_XON && rx_char_i == xon_b_i) begin
              xon_hit_o = 1'b1; keep_d = 1'b0; flush_d = 1'b0;
            end else if (pend_q == PEND_XOFF && rx_char_i == xoff_b_i) begin
              xoff_hit_o = 1'b1; keep_d = 1'b0; flush_d = 1'b0;
            end else if (rx_char_i == xon_a_i) begin
              pend_d = PEND_XON; keep_d = 1'b0;
            end else if (rx_char_i == xoff_a_i) begin
              pend_d = PEND_XOFF; keep_d = 1'b0;
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q       <= PEND_NONE;
      pend_char_q  <= '0;
      out_valid_o  <= 1'b0;
      keep_o       <= 1'b0;
      flush_o      <= 1'b0;
      flush_char_o <= '0;
    end else begin
      out_valid_o <= rx_valid_i;
      flush_o     <= flush_d;
      if (rx_valid_i) begin
        keep_o       <= keep_d;
        flush_char_o <= pend_char_q;
        pend_q       <= pend_d;
        if (pend_d != PEND_NONE) pend_char_q <= rx_char_i;
      end
    end
  end
endmodule

// File: rtl/xflow_halt_ctrl.sv
module xflow_halt_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_valid_i,
  input  logic xon_hit_i,
  input  logic xoff_hit_i,
  input  logic spec_hit_i,
  input  logic any_resume_i,
  input  logic xoff_irq_en_i,
  input  logic iir_read_i,
  input  logic tx_busy_i,
  output logic tx_halt_o,
  output logic xoff_irq_o
);
  logic halt_req_q, irq_stop_q, irq_spec_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      halt_req_q <= 1'b0;
      irq_stop_q <= 1'b0;
    end else if (xoff_hit_i) begin
      halt_req_q <= 1'b1;
      if (xoff_irq_en_i) irq_stop_q <= 1'b1;
    end else if (xon_hit_i) begin
      halt_req_q <= 1'b0;
      irq_stop_q <= 1'b0;
    end else if (rx_valid_i && any_resume_i) begin
      halt_req_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        irq_spec_q <= 1'b0;
    else if (spec_hit_i && xoff_irq_en_i) irq_spec_q <= 1'b1;
    else if (iir_read_i)                irq_spec_q <= 1'b0;
  end

  // halt only takes effect at a character boundary
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         tx_halt_o <= 1'b0;
    else if (!tx_busy_i) tx_halt_o <= halt_req_q;
  end

  assign xoff_irq_o = irq_stop_q | irq_spec_q;
endmodule

// File: rtl/xflow_tx_insert.sv
module xflow_tx_insert
  import xflow_pkg::*;
#(
  parameter int CW    = 8,
  parameter int LVL_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CW-1:0]    xon_a_i,
  input  logic [CW-1:0]    xon_b_i,
  input  logic [CW-1:0]    xoff_a_i,
  input  logic [CW-1:0]    xoff_b_i,
  input  logic [1:0]       tx_mode_i,
  input  logic [1:0]       word_len_i,
  input  logic [LVL_W-1:0] fifo_level_i,
  input  logic [LVL_W-1:0] halt_thr_i,
  input  logic [LVL_W-1:0] resume_thr_i,
  input  logic             ins_ack_i,
  output logic             ins_req_o,
  output logic [CW-1:0]    ins_char_o
);
  localparam int MIN_BITS = 5;
  ins_e       st_q;
  logic       stop_sent_q, kind_stop_q;
  logic [1:0] mode_q;
  logic [CW-1:0] raw_char, len_mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= INS_IDLE;
      stop_sent_q <= 1'b0;
      kind_stop_q <= 1'b0;
      mode_q      <= MODE_OFF;
    end else begin
      unique case (st_q)
        INS_IDLE: if (tx_mode_i != MODE_OFF) begin
          if (!stop_sent_q && fifo_level_i >= halt_thr_i) begin
            st_q <= INS_FIRST; kind_stop_q <= 1'b1; stop_sent_q <= 1'b1;
            mode_q <= tx_mode_i;
          end else if (stop_sent_q && fifo_level_i <= resume_thr_i) begin
            st_q <= INS_FIRST; kind_stop_q <= 1'b0; stop_sent_q <= 1'b0;
            mode_q <= tx_mode_i;
          end
        end
        INS_FIRST:  if (ins_ack_i) st_q <= (mode_q == MODE_BOTH) ? INS_SECOND : INS_IDLE;
        INS_SECOND: if (ins_ack_i) st_q <= INS_IDLE;
        default:    st_q <= INS_IDLE;
      endcase
    end
  end

  always_comb begin
    if (st_q == INS_SECOND || mode_q == MODE_B)
      raw_char = kind_stop_q ? xoff_b_i : xon_b_i;
    else
      raw_char = kind_stop_q ? xoff_a_i : xon_a_i;
    len_mask = {CW{1'b1}} >> (CW - MIN_BITS - int'(word_len_i));
  end

  assign ins_req_o  = (st_q != INS_IDLE);
  assign ins_char_o = raw_char & len_mask;
endmodule

// File: rtl/xflow_ctrl.sv
module xflow_ctrl #(
  parameter int LVL_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rx_valid_i,
  input  logic [7:0]       rx_char_i,
  input  logic [7:0]       xon_a_i,
  input  logic [7:0]       xon_b_i,
  input  logic [7:0]       xoff_a_i,
  input  logic [7:0]       xoff_b_i,
  input  logic [1:0]       rx_mode_i,
  input  logic [1:0]       tx_mode_i,
  input  logic             any_resume_i,
  input  logic             special_en_i,
  input  logic             xoff_irq_en_i,
  input  logic             iir_read_i,
  input  logic [1:0]       word_len_i,
  input  logic [LVL_W-1:0] fifo_level_i,
  input  logic [LVL_W-1:0] halt_thr_i,
  input  logic [LVL_W-1:0] resume_thr_i,
  input  logic             tx_busy_i,
  input  logic             ins_ack_i,
  output logic             tx_halt_o,
  output logic             ins_req_o,
  output logic [7:0]       ins_char_o,
  output logic             rx_out_valid_o,
  output logic             rx_keep_o,
  output logic             flush_o,
  output logic [7:0]       flush_char_o,
  output logic             xoff_irq_o
);
  logic xon_hit, xoff_hit, spec_hit;

  xflow_rx_match #(.CW(8)) u_match (
    .clk_i, .rst_ni, .rx_valid_i, .rx_char_i,
    .xon_a_i, .xon_b_i, .xoff_a_i, .xoff_b_i,
    .rx_mode_i, .special_en_i,
    .xon_hit_o(xon_hit), .xoff_hit_o(xoff_hit), .spec_hit_o(spec_hit),
    .out_valid_o(rx_out_valid_o), .keep_o(rx_keep_o),
    .flush_o, .flush_char_o
  );

  xflow_halt_ctrl u_halt (
    .clk_i, .rst_ni, .rx_valid_i,
    .xon_hit_i(xon_hit), .xoff_hit_i(xoff_hit), .spec_hit_i(spec_hit),
    .any_resume_i, .xoff_irq_en_i, .iir_read_i, .tx_busy_i,
    .tx_halt_o, .xoff_irq_o
  );

  xflow_tx_insert #(.CW(8), .LVL_W(LVL_W)) u_ins (
    .clk_i, .rst_ni, .xon_a_i, .xon_b_i, .xoff_a_i, .xoff_b_i,
    .tx_mode_i, .word_len_i, .fifo_level_i, .halt_thr_i, .resume_thr_i,
    .ins_ack_i, .ins_req_o, .ins_char_o
  );
endmodule

// File: rtl/xflow_ctrl_chk.sv
module xflow_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       rx_valid_i,
  input logic [7:0] rx_char_i,
  input logic [7:0] xoff_b_i,
  input logic [1:0] rx_mode_i,
  input logic [1:0] tx_mode_i,
  input logic       special_en_i,
  input logic [1:0] word_len_i,
  input logic       tx_busy_i,
  input logic       ins_ack_i,
  input logic       tx_halt_o,
  input logic       ins_req_o,
  input logic [7:0] ins_char_o,
  input logic       rx_out_valid_o,
  input logic       rx_keep_o,
  input logic       flush_o
);
  p_no_stray_verdict_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_valid_i |=> (!rx_out_valid_o && !flush_o));

  p_pass_through_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && rx_mode_i == 2'b00 && !special_en_i) |=> (rx_out_valid_o && rx_keep_o));

  p_halt_at_boundary_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_busy_i |=> $stable(tx_halt_o));

  p_special_kept_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && special_en_i && rx_char_i == xoff_b_i) |=> rx_keep_o);

  p_insert_off_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_mode_i == 2'b00 && !ins_req_o) |=> !ins_req_o);

  p_five_bit_mask_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ins_req_o && word_len_i == 2'b00) |-> (ins_char_o[7:5] == 3'b000));

  p_req_held_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ins_req_o && !ins_ack_i) |=> ins_req_o);
endmodule

bind xflow_ctrl xflow_ctrl_chk u_chk (.*);

// File: tb/xflow_ctrl_test.sv
`timescale 1ns/1ps
module xflow_ctrl_test;
  localparam int LVL_W = 7;
  localparam logic [7:0] XON_A = 8'h11, XON_B = 8'h12, XOFF_A = 8'h13, XOFF_B = 8'h14;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_valid = 0; logic [7:0] rx_char = 0;
  logic [7:0] xon_a = XON_A, xon_b = XON_B, xoff_a = XOFF_A, xoff_b = XOFF_B;
  logic [1:0] rx_mode = 0, tx_mode = 0, word_len = 2'd3;
  logic any_resume = 0, special_en = 0, irq_en = 1, iir_read = 0, tx_busy = 0, ins_ack = 0;
  logic [LVL_W-1:0] level = 0, halt_thr = 7'd60, resume_thr = 7'd32;
  logic tx_halt, ins_req, rx_out_valid, rx_keep, flush, xoff_irq;
  logic [7:0] ins_char, flush_char;

  int n_cmp = 0, n_bad = 0;
  typedef struct packed { logic keep; logic fl; logic [7:0] fch; } exp_t;
  exp_t exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  xflow_ctrl #(.LVL_W(LVL_W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .rx_valid_i(rx_valid), .rx_char_i(rx_char),
    .xon_a_i(xon_a), .xon_b_i(xon_b), .xoff_a_i(xoff_a), .xoff_b_i(xoff_b),
    .rx_mode_i(rx_mode), .tx_mode_i(tx_mode), .any_resume_i(any_resume),
    .special_en_i(special_en), .xoff_irq_en_i(irq_en), .iir_read_i(iir_read),
    .word_len_i(word_len), .fifo_level_i(level), .halt_thr_i(halt_thr),
    .resume_thr_i(resume_thr), .tx_busy_i(tx_busy), .ins_ack_i(ins_ack),
    .tx_halt_o(tx_halt), .ins_req_o(ins_req), .ins_char_o(ins_char),
    .rx_out_valid_o(rx_out_valid), .rx_keep_o(rx_keep), .flush_o(flush),
    .flush_char_o(flush_char), .xoff_irq_o(xoff_irq)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  // driver: one character, expected verdict pushed to scoreboard
  task automatic send(string tag, logic [7:0] c, logic keep, logic fl, logic [7:0] fch);
    @(negedge clk);
    exp_q.push_back('{keep: keep, fl: fl, fch: fch});
    tag_q.push_back(tag);
    rx_valid = 1; rx_char = c;
    @(negedge clk);
    rx_valid = 0;
  endtask

  task automatic ack();
    @(negedge clk); ins_ack = 1;
    @(negedge clk); ins_ack = 0;
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && rx_out_valid) begin
      if (exp_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R1 unexpected verdict actual=1 expected=0");
      end else begin
        exp_t e; string t;
        e = exp_q.pop_front(); t = tag_q.pop_front();
        check({t, " keep"}, rx_keep, e.keep);
        check({t, " flush"}, flush, e.fl);
        if (e.fl) check({t, " flush_char"}, flush_char, e.fch);
      end
    end
  end

  initial begin : watchdog
    #(4 * 100000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    cyc(3);
    check("R1 halt", tx_halt, 0); check("R1 req", ins_req, 0);
    check("R1 irq", xoff_irq, 0); check("R1 valid", rx_out_valid, 0);
    check("R1 flush", flush, 0);
    rst_n = 1; cyc(2);

    // R2: no matching
    rx_mode = 2'b00;
    send("R2 xoff passes", XOFF_A, 1, 0, 0);
    cyc(2); check("R2 no halt", tx_halt, 0);

    // R3 / R7: single pair A
    rx_mode = 2'b10;
    send("R3 data", 8'h41, 1, 0, 0);
    send("R3 xoff_a", XOFF_A, 0, 0, 0);
    cyc(1); check("R3 halted", tx_halt, 1); check("R7 irq set", xoff_irq, 1);
    send("R3 xon_a", XON_A, 0, 0, 0);
    cyc(1); check("R3 resumed", tx_halt, 0); check("R7 irq cleared", xoff_irq, 0);
    // pair B
    rx_mode = 2'b01;
    send("R3 xoff_a ignored in B", XOFF_A, 1, 0, 0);
    send("R3 xoff_b", XOFF_B, 0, 0, 0);
    cyc(1); check("R3 B halted", tx_halt, 1);
    send("R3 xon_b", XON_B, 0, 0, 0);
    cyc(1); check("R3 B resumed", tx_halt, 0);

    // R6: halt deferred while busy
    rx_mode = 2'b10; tx_busy = 1;
    send("R6 xoff", XOFF_A, 0, 0, 0);
    cyc(3); check("R6 held while busy", tx_halt, 0);
    tx_busy = 0; cyc(1); check("R6 halted after char", tx_halt, 1);
    send("R6 xon", XON_A, 0, 0, 0); cyc(1);

    // R7: interrupt disabled
    irq_en = 0;
    send("R7 xoff no irq", XOFF_A, 0, 0, 0);
    cyc(1); check("R7 halt w/o irq", tx_halt, 1); check("R7 irq off", xoff_irq, 0);
    send("R7 xon", XON_A, 0, 0, 0); cyc(1);
    irq_en = 1;

    // R8: resume on any
    send("R8 xoff", XOFF_A, 0, 0, 0); cyc(1);
    check("R8 halted", tx_halt, 1);
    any_resume = 1;
    send("R8 any char", 8'h41, 1, 0, 0);
    cyc(1); check("R8 resumed", tx_halt, 0); check("R8 irq kept", xoff_irq, 1);
    any_resume = 0;
    send("R8 xon clears", XON_A, 0, 0, 0);
    cyc(1); check("R8 irq cleared by xon", xoff_irq, 0);

    // R9: special character
    special_en = 1;
    send("R9 special A mode", XOFF_B, 1, 0, 0);
    cyc(1); check("R9 no halt", tx_halt, 0); check("R9 irq", xoff_irq, 1);
    @(negedge clk); iir_read = 1; @(negedge clk); iir_read = 0;
    check("R9 irq cleared by read", xoff_irq, 0);
    rx_mode = 2'b01;
    send("R9 special B mode", XOFF_B, 1, 0, 0);
    cyc(1); check("R9 B no halt", tx_halt, 0);
    @(negedge clk); iir_read = 1; @(negedge clk); iir_read = 0;
    special_en = 0;

    // R4 / R5: sequential pairs
    rx_mode = 2'b11;
    send("R4 xoff_a held", XOFF_A, 0, 0, 0);
    send("R4 xoff_b", XOFF_B, 0, 0, 0);
    cyc(1); check("R4 halted", tx_halt, 1);
    send("R4 xon_b alone", XON_B, 1, 0, 0);
    cyc(1); check("R4 still halted", tx_halt, 1);
    send("R4 xon_a held", XON_A, 0, 0, 0);
    send("R4 xon_b", XON_B, 0, 0, 0);
    cyc(1); check("R4 resumed", tx_halt, 0);
    send("R5 xoff_a held", XOFF_A, 0, 0, 0);
    send("R5 mismatch", 8'h41, 1, 1, XOFF_A);
    send("R5 xon_a held", XON_A, 0, 0, 0);
    send("R5 xoff_a restarts", XOFF_A, 0, 1, XON_A);
    send("R5 xoff_b", XOFF_B, 0, 0, 0);
    cyc(1); check("R5 halted", tx_halt, 1);
    send("R5 xon_a", XON_A, 0, 0, 0);
    send("R5 xon_b", XON_B, 0, 0, 0);
    cyc(1); check("R5 resumed", tx_halt, 0);
    rx_mode = 2'b00;

    // R10 / R13: insertion thresholds, A codes
    tx_mode = 2'b10; level = 7'd59; cyc(3);
    check("R10 below halt", ins_req, 0);
    level = 7'd60; cyc(1);
    check("R10 stop req", ins_req, 1); check("R10 stop char", ins_char, XOFF_A);
    cyc(3); check("R13 held", ins_req, 1); check("R13 char held", ins_char, XOFF_A);
    ack(); check("R10 done", ins_req, 0);
    cyc(3); check("R10 once per crossing", ins_req, 0);
    level = 7'd40; cyc(3); check("R10 above resume", ins_req, 0);
    level = 7'd32; cyc(1);
    check("R10 resume req", ins_req, 1); check("R10 resume char", ins_char, XON_A);
    ack(); check("R10 resume done", ins_req, 0);

    // R11: both pairs back to back, B alone, off
    tx_mode = 2'b11; level = 7'd61; cyc(1);
    check("R11 first", ins_char, XOFF_A);
    ack(); check("R11 second req", ins_req, 1); check("R11 second", ins_char, XOFF_B);
    ack(); check("R11 idle", ins_req, 0);
    level = 7'd10; cyc(1); check("R11 xon first", ins_char, XON_A);
    ack(); check("R11 xon second", ins_char, XON_B);
    ack();
    tx_mode = 2'b01; level = 7'd60; cyc(1);
    check("R11 B mode char", ins_char, XOFF_B);
    ack(); level = 7'd0; cyc(1); check("R11 B xon", ins_char, XON_B);
    ack();
    tx_mode = 2'b00; level = 7'd64; cyc(4);
    check("R11 off no req", ins_req, 0);

    // R12: word length masking
    xoff_a = 8'hF3; word_len = 2'd0; tx_mode = 2'b10; cyc(1);
    check("R12 5-bit", ins_char, 8'h13);
    word_len = 2'd2; #0; cyc(0); check("R12 7-bit", ins_char, 8'h73);
    word_len = 2'd3; #1; check("R12 8-bit", ins_char, 8'hF3);
    ack(); level = 7'd0; xoff_a = XOFF_A; cyc(1);
    ack();

    cyc(4);
    if (exp_q.size() != 0) begin
      n_cmp++; n_bad++;
      $display("FAIL R1 missing verdicts actual=%0d expected=0", exp_q.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule